// File: doc/BRIEF.md
# LFSR-Addressed Waveform Generator with Phase Select

This block plays a stored waveform without a binary phase counter. A maximal-length shift register in Galois form steps once per enabled clock, and its state is used directly as the read address of a sample memory. Software fills the memory in the order the register visits its states, so stepping the register plays the samples in order. The register can run at the bare flip-flop rate because each stage sees at most one two-input XOR.

The phase of the playback is chosen in one clock. The register state is a point on a single cyclic sequence, and any later point is a fixed linear (XOR) function of the current state. The block uses this shift-and-add property in two cascaded N:1 selectors, one coarse and one fine, where N equals the register width. Together they give N×N distinct phase offsets. The selects are registered, and the memory read is synchronous, so a new phase appears on the output with a fixed latency.

The reset input is asserted asynchronously and released through a two-stage synchronizer. The sample memory itself is not reset. It can be written at any time, including while the block is held in reset.

Top module: `lfsr_wavegen`

## Requirements
- R1: While reset is asserted, and for the first two clock edges after `rst_n` rises, `sample_o` is 0. The register starts at seed state 1, and both selects start at 0.
- R2: On each edge with `en` high, the register state s (width W, default 8) becomes (s >> 1) XOR (s[0] ? MASK : 0), where MASK is the primitive-polynomial mask (0xB8 for W = 8). The state is never zero.
- R3: With `en` held high, the register returns to its seed state, and the output sequence repeats, every 2^W − 1 steps.
- R4: An edge with `en` low leaves the register state unchanged. With the selects also unchanged, the output keeps reading the same address.
- R5: `sample_o` is registered. After an edge, it holds the memory word at the address formed from the register state and the select registers as they stood before that edge.
- R6: The read address is the register state advanced by c·CSTEP + f steps. Here c is the registered coarse select, f is the registered fine select, each lies in 0..N−1 with N = W, and CSTEP = floor((2^W − 1)/N), which is 31 for W = 8. Select values of N or above act as 0.
- R7: A select value present at an edge is registered there and steers the read at the next edge. The output therefore reflects a new phase two edges after the select changes.
- R8: A write with `wr_en_i` high stores `wr_data_i` at `wr_addr_i` on the clock edge. A read at that same edge returns the old word, and a read at a later edge returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Step enable for the sequence register |
| sel_coarse_i | input | $clog2(W) | Coarse phase select, in units of CSTEP steps |
| sel_fine_i | input | $clog2(W) | Fine phase select, in single steps |
| wr_en_i | input | 1 | Sample memory write strobe |
| wr_addr_i | input | W | Sample memory write address |
| wr_data_i | input | DW | Sample to store |
| sample_o | output | DW | Registered output sample |

## Verification
The memory is loaded so that the word at each state holds that state's position in the sequence. The expected output is then the step count plus the selected offset, taken modulo 2^W − 1. Any wrong feedback tap, wrong seed or missed step shows up as a jump in that count, and a design with a short cycle fails the check that compares values one full period apart. All 64 coarse/fine pairs are swept. A selector with a wrong advance matrix, swapped coarse and fine inputs, or a missing select register produces an output that is off by the wrong offset or lands a cycle early. Irregular enable patterns catch a register that drifts while idle. A write to the address currently being read exposes a memory that returns the new word at the edge of the write instead of one edge later.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

  // Galois right-shift feedback masks for maximal-length sequences.
  function automatic logic [31:0] lfsr_mask(input int unsigned w);
    logic [31:0] m;
    case (w)
      3:       m = 32'h0000_0006;
      4:       m = 32'h0000_000C;
      5:       m = 32'h0000_0014;
      6:       m = 32'h0000_0030;
      7:       m = 32'h0000_0060;
      8:       m = 32'h0000_00B8;
      9:       m = 32'h0000_0110;
      10:      m = 32'h0000_0240;
      11:      m = 32'h0000_0500;
      12:      m = 32'h0000_0E08;
      13:      m = 32'h0000_1C80;
      14:      m = 32'h0000_3802;
      15:      m = 32'h0000_6000;
      16:      m = 32'h0000_D008;
      17:      m = 32'h0001_2000;
      18:      m = 32'h0002_0400;
      19:      m = 32'h0007_2000;
      20:      m = 32'h0009_0000;
      default: m = 32'h0000_00B8;
    endcase
    return m;
  endfunction

  // One Galois step on a zero-extended state.
  function automatic logic [31:0] lfsr_step(input logic [31:0] s, input logic [31:0] m);
    return (s >> 1) ^ (s[0] ? m : 32'h0);
  endfunction

  // k Galois steps, used only at elaboration to build advance columns.
  function automatic logic [31:0] lfsr_adv(input logic [31:0] s, input logic [31:0] m,
                                           input int unsigned k);
    logic [31:0] v;
    v = s;
    for (int unsigned n = 0; n < k; n++) v = lfsr_step(v, m);
    return v;
  endfunction

endpackage

// File: rtl/lfsr_core.sv
module lfsr_core #(
  parameter int unsigned W    = 8,
  parameter int unsigned SEED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] state_o
);
  import wavegen_pkg::*;

  localparam logic [31:0]  MASK   = lfsr_mask(W);
  localparam logic [W-1:0] SEED_V = W'(SEED);
  localparam int unsigned  PERIOD = (1 << W) - 1;

  logic [W-1:0] st_q;
  logic [W-1:0] st_d;

  // next state: per-stage feedback, no XOR tree
  always_comb begin
    st_d = st_q;
    if (en) begin
      st_d = {1'b0, st_q[W-1:1]} ^ (st_q[0] ? MASK[W-1:0] : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED_V;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // step counter for the period check, independent of the state logic
  logic [W-1:0] chk_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  chk_cnt_q <= '0;
    else if (en) chk_cnt_q <= (chk_cnt_q == W'(PERIOD - 1)) ? '0 : chk_cnt_q + 1'b1;
  end

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) st_q != '0);

  // R4
  lfsr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(st_q));

  // R3
  lfsr_period_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && chk_cnt_q == W'(PERIOD - 1)) |-> st_d == SEED_V);

  // R3
  lfsr_no_short_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_d == SEED_V) |-> chk_cnt_q == W'(PERIOD - 1));

endmodule

// File: rtl/phase_xform.sv
module phase_xform #(
  parameter int unsigned W    = 8,
  parameter int unsigned N    = 8,
  parameter int unsigned STEP = 1,
  parameter int unsigned SW   = 3
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] sel,
  output logic [W-1:0]  dout
);
  import wavegen_pkg::*;

  localparam logic [31:0] MASK = lfsr_mask(W);

  // col[j][i]: image of unit vector i after j*STEP steps
  logic [W-1:0] col [N][W];

  for (genvar j = 0; j < N; j++) begin : g_ofs
    for (genvar i = 0; i < W; i++) begin : g_bit
      localparam logic [31:0] CV = lfsr_adv(32'h1 << i, MASK, j * STEP);
      assign col[j][i] = CV[W-1:0];
    end
  end

  logic [SW-1:0] idx;
  logic [W-1:0]  acc;

  always_comb begin
    idx = ({1'b0, sel} < (SW+1)'(N)) ? sel : '0;
    acc = '0;
    for (int i = 0; i < W; i++) begin
      if (din[i]) acc = acc ^ col[idx][i];
    end
  end

  assign dout = acc;

endmodule

// File: rtl/sample_ram.sv
module sample_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;
  logic [DW-1:0] rd_d;

  // storage is not reset; writable at any time
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rd_d = mem_q[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;

endmodule

// File: rtl/lfsr_wavegen.sv
module lfsr_wavegen #(
  parameter int unsigned W  = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [SW-1:0] sel_coarse_i,
  input  logic [SW-1:0] sel_fine_i,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] sample_o
);
  localparam int unsigned N      = W;
  localparam int unsigned PERIOD = (1 << W) - 1;
  localparam int unsigned CSTEP  = PERIOD / N;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  // registered phase selects
  logic [SW-1:0] sel_c_q, sel_c_d;
  logic [SW-1:0] sel_f_q, sel_f_d;

  always_comb begin
    sel_c_d = sel_coarse_i;
    sel_f_d = sel_fine_i;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sel_c_q <= '0;
      sel_f_q <= '0;
    end else begin
      sel_c_q <= sel_c_d;
      sel_f_q <= sel_f_d;
    end
  end

  logic [W-1:0] state;
  logic [W-1:0] mid_addr;
  logic [W-1:0] rd_addr;

  lfsr_core #(.W(W), .SEED(1)) u_core (
    .clk    (clk),
    .rst_n  (rst_i),
    .en     (en),
    .state_o(state)
  );

  phase_xform #(.W(W), .N(N), .STEP(CSTEP), .SW(SW)) u_coarse (
    .din (state),
    .sel (sel_c_q),
    .dout(mid_addr)
  );

  phase_xform #(.W(W), .N(N), .STEP(1), .SW(SW)) u_fine (
    .din (mid_addr),
    .sel (sel_f_q),
    .dout(rd_addr)
  );

  sample_ram #(.AW(W), .DW(DW)) u_ram (
    .clk  (clk),
    .rst_n(rst_i),
    .we   (wr_en_i),
    .waddr(wr_addr_i),
    .wdata(wr_data_i),
    .raddr(rd_addr),
    .rdata(sample_o)
  );

  // R6
  rd_addr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_i)
    rd_addr != '0);

  // R6
  fine_zero_ofs_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (sel_f_q == '0) |-> rd_addr == mid_addr);

endmodule

// File: tb/lfsr_wavegen_bench.sv
`timescale 1ns/1ps
module lfsr_wavegen_bench;
  localparam int W   = 8;
  localparam int D   = 8;
  localparam int P   = 255;
  localparam int N   = 8;
  localparam int CST = 31;
  localparam logic [7:0] MASK = 8'hB8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [2:0] sel_c, sel_f;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] sample;

  always #2.5 clk = ~clk;

  lfsr_wavegen #(.W(W), .DW(D)) u_lfsr_wavegen (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .sel_coarse_i(sel_c),
    .sel_fine_i  (sel_f),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .sample_o    (sample)
  );

  int total = 0;
  int bad   = 0;
  logic [7:0] seq   [P];
  logic [7:0] mem_m [256];
  int k, cq, fq;
  logic [7:0] smp_m;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] raddr_m();
    return seq[(k + cq * CST + fq) % P];
  endfunction

  // one clock: compare, advance model, drive
  task automatic cyc(input string tag, input bit e, input int c, input int f);
    check(tag, sample, smp_m);
    smp_m = mem_m[raddr_m()];
    cq = c;
    fq = f;
    if (e) k = (k + 1) % P;
    en    = e;
    sel_c = 3'(c);
    sel_f = 3'(f);
    wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wcyc(input string tag, input logic [7:0] a, input logic [7:0] d);
    check(tag, sample, smp_m);
    smp_m = mem_m[raddr_m()];
    mem_m[a] = d;
    en      = 1'b0;
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [7:0] keep;
    logic [7:0] wa;
    s = 8'h01;
    for (int j = 0; j < P; j++) begin
      seq[j] = s;
      s = {1'b0, s[7:1]} ^ (s[0] ? MASK : 8'h00);
    end
    rst_n = 1'b0; en = 1'b0; sel_c = '0; sel_f = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1", sample, 8'h00);
    // load memory during reset: word at state j holds j
    for (int j = 0; j < P; j++) begin
      wr_en = 1'b1; wr_addr = seq[j]; wr_data = 8'(j);
      mem_m[seq[j]] = 8'(j);
      @(posedge clk);
      @(negedge clk);
    end
    wr_en = 1'b1; wr_addr = 8'h00; wr_data = 8'hEE; mem_m[0] = 8'hEE;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check("R1", sample, 8'h00);
    rst_n = 1'b1;
    for (int j = 0; j < 2; j++) begin
      @(posedge clk);
      @(negedge clk);
      check("R1", sample, 8'h00);
    end
    k = 0; cq = 0; fq = 0; smp_m = 8'h00;

    // R5 first reads; R1 seed gives index 0 after the first active edge
    cyc("R5", 1'b1, 0, 0);
    check("R1", sample, 8'h00);
    for (int i = 0; i < 4; i++) cyc("R5", 1'b1, 0, 0);

    // R2 / R3 free run over two periods
    keep = 8'h00;
    for (int i = 0; i < 2 * P + 4; i++) begin
      if (i == 10) keep = sample;
      if (i == 10 + P) check("R3", sample, keep);
      cyc((i < P) ? "R2" : "R3", 1'b1, 0, 0);
    end

    // R6 / R7 sweep every coarse/fine pair
    for (int c = 0; c < N; c++) begin
      for (int f = 0; f < N; f++) begin
        cyc("R7", 1'b1, c, f);
        cyc("R7", 1'b1, c, f);
        cyc("R6", 1'b1, c, f);
      end
    end

    // R4 irregular enable with changing phases
    for (int i = 0; i < 90; i++) cyc("R4", (i % 3) != 0, i % N, (i * 5) % N);
    for (int i = 0; i < 6; i++) cyc("R4", 1'b0, 5, 1);

    // R8 write to the address being read while idle
    cyc("R8", 1'b0, 2, 3);
    cyc("R8", 1'b0, 2, 3);
    wa = raddr_m();
    wcyc("R8", wa, 8'hA5);
    cyc("R8", 1'b0, 2, 3);
    cyc("R8", 1'b0, 2, 3);
    check("R8", sample, 8'hA5);
    // write elsewhere: output unchanged
    wcyc("R8", seq[(k + 2 * CST + 3 + 7) % P], 8'h5A);
    cyc("R8", 1'b0, 2, 3);
    cyc("R8", 1'b0, 2, 3);
    check("R8", sample, 8'hA5);
    // run on, then come back around to the rewritten word
    for (int i = 0; i < P + 3; i++) cyc("R8", 1'b1, 2, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule